// File: doc/BRIEF.md
# Write-Only I2C Command and Display-Data Receiver

This block is the serial front end of a character display controller. It sits on an I2C bus as a receive-only target. It answers one of four consecutive 7-bit addresses, and two strap pins pick which one. The bus lines are open-drain. The block samples them with its own system clock and pulls SDA low only to acknowledge.

Once the block has accepted its address, the master sends a stream of control bytes and payload bytes. A control byte carries two flags:
- A continuation flag says whether another control byte will come after the next payload byte. If it does not, every following byte up to STOP is payload.
- A register-select flag steers each payload byte. It goes either to a one-cycle command strobe or to a display-RAM write port.

The RAM write port has its own address pointer. The pointer advances after every write and keeps its value from one transfer to the next.

The block does not execute commands. It only presents the command byte with a strobe to the logic that decodes it.

Top module: `dispctl_i2c_sink`

## Requirements
- R1: The block acknowledges an address byte whose upper five bits are 01111, whose next two bits equal `addr_sel_i[1:0]`, and whose least significant (read/write) bit is 0.
- R2: An address byte with a matching 7-bit address but the read/write bit set to 1 is not acknowledged.
- R3: After a non-matching address, the block drives no acknowledge and produces no strobe or RAM write until the next START condition.
- R4: While addressed, every control and payload byte is acknowledged by holding `sda_pull_o` high across the ninth SCL clock. SDA is pulled and released only while SCL is low.
- R5: A control byte with bit 7 (continuation) set is followed by exactly one payload byte, and the byte after that is again treated as a control byte.
- R6: After a control byte with bit 7 clear, every byte up to STOP is a payload byte routed by that control byte.
- R7: Bit 6 of the control byte selects the destination: 1 means RAM, 0 means command. Bits 5..0 of a control byte have no effect.
- R8: A payload routed to the command path appears on `cmd_byte_o` with `cmd_stb_o` high for exactly one clock.
- R9: A payload routed to RAM appears on `ram_data_o`, with `ram_addr_o` equal to the pointer, and `ram_we_o` high for one clock. The pointer then increments, wrapping from 127 to 0.
- R10: A START or STOP in the middle of a byte discards the partial byte, and the next byte is parsed as an address. The RAM pointer keeps its value.
- R11: After reset, `sda_pull_o`, `cmd_stb_o` and `ram_we_o` are low and the RAM pointer is 0.
- R12: `cmd_stb_o` and `ram_we_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel_i | input | 2 | Strap pins forming the two low address bits |
| sda_pull_o | output | 1 | High to pull SDA low (acknowledge) |
| cmd_byte_o | output | 8 | Command byte presented with the strobe |
| cmd_stb_o | output | 1 | One-cycle command strobe |
| ram_addr_o | output | 7 | Display-RAM write address |
| ram_data_o | output | 8 | Display-RAM write data |
| ram_we_o | output | 1 | One-cycle display-RAM write enable |

## Verification
The bench targets the following corner cases.

- **Read bit or wrong address.** Sending a matching address with the read bit set, or another target's address, must not be acknowledged. A design that skipped the read/write check, or kept listening after a mismatch, would acknowledge, or would write bytes that were never meant for it.
- **Repeated START after continuation-clear mode.** A repeated START follows a control byte with the continuation flag clear, and the next control byte is then sent. A parser that was not reset would treat that control byte as RAM data.
- **Partial byte cut off by STOP.** A payload byte is cut short by STOP. A design that kept the half-shifted bits would misalign the next address.
- **Pointer wrap.** A burst of 130 RAM bytes crosses the 127-to-0 boundary. A pointer that saturated, or was cleared between transfers, would show the wrong address against the bench model.

// File: rtl/dispctl_i2c_pkg.sv
package dispctl_i2c_pkg;

   // Payload width on the bus
   localparam int BYTE_W = 8;

   // Fixed upper bits of the 7-bit target address
   localparam logic [4:0] ADDR_PREFIX = 5'b01111;

   // Control-byte flag positions
   localparam int CTRL_CONT_BIT = 7;
   localparam int CTRL_SEL_BIT  = 6;

   // What the parser expects next after the address
   typedef enum logic [1:0] {
      PS_CTRL = 2'd0,   // a control byte
      PS_ONE  = 2'd1,   // one payload byte, then a control byte
      PS_TAIL = 2'd2    // payload bytes until STOP
   } parse_e;

endpackage

// File: rtl/dispctl_i2c_sync.sv
module dispctl_i2c_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic sda_bit
);

   // Synchronizer chain, one generate scope per stage
   for (genvar i = 0; i < STAGES; i++) begin : g_st
      logic scl_r, sda_r;
      logic scl_d, sda_d;
      if (i == 0) begin : g_in
         assign scl_d = scl_i;
         assign sda_d = sda_i;
      end else begin : g_ch
         assign scl_d = g_st[i-1].scl_r;
         assign sda_d = g_st[i-1].sda_r;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_r <= 1'b1;
            sda_r <= 1'b1;
         end else begin
            scl_r <= scl_d;
            sda_r <= sda_d;
         end
      end
   end

   logic scl_s, sda_s;
   logic scl_q, sda_q;

   assign scl_s = g_st[STAGES-1].scl_r;
   assign sda_s = g_st[STAGES-1].sda_r;

   // One more flop for edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
   assign sda_bit   = sda_s;

endmodule

// File: rtl/dispctl_i2c_shift.sv
module dispctl_i2c_shift
   import dispctl_i2c_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_bit,
   input  logic [1:0]        addr_sel,
   output logic              sda_pull,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_q,
   output logic              frame_rst
);

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   logic              listen;     // tracking bits of this transfer
   logic              in_addr;    // current byte is the address
   logic              addressed;  // address matched
   logic [CNT_W-1:0]  bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic              got_byte;
   logic              ack_arm;
   logic              pull;
   logic              addr_hit;

   assign addr_hit = (shreg[7:3] == ADDR_PREFIX) &&
                     (shreg[2:1] == addr_sel) && !shreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         listen    <= 1'b0;
         in_addr   <= 1'b0;
         addressed <= 1'b0;
         bitcnt    <= '0;
         shreg     <= '0;
         got_byte  <= 1'b0;
         ack_arm   <= 1'b0;
         pull      <= 1'b0;
      end else begin
         got_byte <= 1'b0;
         if (start_det) begin
            listen    <= 1'b1;
            in_addr   <= 1'b1;
            addressed <= 1'b0;
            bitcnt    <= '0;
            ack_arm   <= 1'b0;
            pull      <= 1'b0;
         end else if (stop_det) begin
            listen    <= 1'b0;
            in_addr   <= 1'b0;
            addressed <= 1'b0;
            bitcnt    <= '0;
            ack_arm   <= 1'b0;
            pull      <= 1'b0;
         end else begin
            if (scl_rise && listen && (bitcnt < CNT_FULL)) begin
               shreg  <= {shreg[BYTE_W-2:0], sda_bit};
               bitcnt <= bitcnt + 1'b1;
               if (bitcnt == CNT_LAST) got_byte <= 1'b1;
            end
            if (got_byte) begin
               if (in_addr) begin
                  in_addr <= 1'b0;
                  if (addr_hit) begin
                     addressed <= 1'b1;
                     ack_arm   <= 1'b1;
                  end else begin
                     listen <= 1'b0;
                     bitcnt <= '0;
                  end
               end else begin
                  ack_arm <= 1'b1;
               end
            end
            if (scl_fall && (bitcnt == CNT_FULL)) begin
               if (ack_arm && !pull) begin
                  pull <= 1'b1;
               end else begin
                  pull    <= 1'b0;
                  ack_arm <= 1'b0;
                  bitcnt  <= '0;
               end
            end
         end
      end
   end

   assign sda_pull  = pull;
   assign byte_vld  = got_byte && !in_addr && addressed;
   assign byte_q    = shreg;
   assign frame_rst = start_det | stop_det;

endmodule

// File: rtl/dispctl_i2c_parse.sv
module dispctl_i2c_parse
   import dispctl_i2c_pkg::*;
#(
   parameter int RAM_AW = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_rst,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_q,
   output logic [BYTE_W-1:0] cmd_byte,
   output logic              cmd_stb,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [BYTE_W-1:0] ram_data,
   output logic              ram_we
);

   parse_e            st;
   logic              to_ram;
   logic [RAM_AW-1:0] ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= PS_CTRL;
         to_ram   <= 1'b0;
         ptr      <= '0;
         cmd_byte <= '0;
         cmd_stb  <= 1'b0;
         ram_addr <= '0;
         ram_data <= '0;
         ram_we   <= 1'b0;
      end else begin
         cmd_stb <= 1'b0;
         ram_we  <= 1'b0;
         if (frame_rst) begin
            st <= PS_CTRL;
         end else if (byte_vld) begin
            if (st == PS_CTRL) begin
               to_ram <= byte_q[CTRL_SEL_BIT];
               st     <= byte_q[CTRL_CONT_BIT] ? PS_ONE : PS_TAIL;
            end else begin
               if (to_ram) begin
                  ram_we   <= 1'b1;
                  ram_data <= byte_q;
                  ram_addr <= ptr;
                  ptr      <= ptr + 1'b1;
               end else begin
                  cmd_stb  <= 1'b1;
                  cmd_byte <= byte_q;
               end
               if (st == PS_ONE) st <= PS_CTRL;
            end
         end
      end
   end

endmodule

// File: rtl/dispctl_i2c_sink.sv
module dispctl_i2c_sink
   import dispctl_i2c_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int RAM_AW      = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [1:0]        addr_sel_i,
   output logic              sda_pull_o,
   output logic [BYTE_W-1:0] cmd_byte_o,
   output logic              cmd_stb_o,
   output logic [RAM_AW-1:0] ram_addr_o,
   output logic [BYTE_W-1:0] ram_data_o,
   output logic              ram_we_o
);

   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 2..4");
   end
   if (RAM_AW < 1 || RAM_AW > 16) begin : g_bad_aw
      $error("RAM_AW must be 1..16");
   end

   logic              scl_rise, scl_fall, start_det, stop_det, sda_bit;
   logic              byte_vld, frame_rst;
   logic [BYTE_W-1:0] byte_q;

   dispctl_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_bit   (sda_bit)
   );

   dispctl_i2c_shift u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_bit   (sda_bit),
      .addr_sel  (addr_sel_i),
      .sda_pull  (sda_pull_o),
      .byte_vld  (byte_vld),
      .byte_q    (byte_q),
      .frame_rst (frame_rst)
   );

   dispctl_i2c_parse #(.RAM_AW(RAM_AW)) u_parse (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_rst (frame_rst),
      .byte_vld  (byte_vld),
      .byte_q    (byte_q),
      .cmd_byte  (cmd_byte_o),
      .cmd_stb   (cmd_stb_o),
      .ram_addr  (ram_addr_o),
      .ram_data  (ram_data_o),
      .ram_we    (ram_we_o)
   );

endmodule

// File: rtl/dispctl_i2c_sink_chk.sv
module dispctl_i2c_sink_chk #(
   parameter int RAM_AW = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_pull_o,
   input logic              cmd_stb_o,
   input logic              ram_we_o,
   input logic [RAM_AW-1:0] ram_addr_o
);

   logic [RAM_AW-1:0] last_addr;
   logic              have_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_addr <= '0;
         have_prev <= 1'b0;
      end else if (ram_we_o) begin
         last_addr <= ram_addr_o;
         have_prev <= 1'b1;
      end
   end

   // R8
   cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb_o |=> !cmd_stb_o);

   // R9
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we_o |=> !ram_we_o);

   // R9
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we_o && have_prev) |-> (ram_addr_o == RAM_AW'(last_addr + 1'b1)));

   // R12
   one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_stb_o && ram_we_o));

   // R4
   pull_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> !scl_i);

   // R4
   release_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull_o) |-> !scl_i);

endmodule

bind dispctl_i2c_sink dispctl_i2c_sink_chk #(.RAM_AW(RAM_AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_i      (scl_i),
   .sda_pull_o (sda_pull_o),
   .cmd_stb_o  (cmd_stb_o),
   .ram_we_o   (ram_we_o),
   .ram_addr_o (ram_addr_o)
);

// File: tb/dispctl_i2c_sink_bench.sv
`timescale 1ns/1ps
module dispctl_i2c_sink_bench;

   localparam int Q = 10;  // quarter SCL period in system clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_drv = 1'b1;
   logic       sda_drv = 1'b1;
   logic [1:0] sel = 2'b10;

   logic       sda_pull_o, cmd_stb_o, ram_we_o;
   logic [7:0] cmd_byte_o, ram_data_o;
   logic [6:0] ram_addr_o;
   wire        sda_line = sda_drv & ~sda_pull_o;

   always #2 clk = ~clk;

   dispctl_i2c_sink u_dispctl_i2c_sink (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_drv),
      .sda_i      (sda_line),
      .addr_sel_i (sel),
      .sda_pull_o (sda_pull_o),
      .cmd_byte_o (cmd_byte_o),
      .cmd_stb_o  (cmd_stb_o),
      .ram_addr_o (ram_addr_o),
      .ram_data_o (ram_data_o),
      .ram_we_o   (ram_we_o)
   );

   int nchk = 0;
   int nbad = 0;
   bit done = 0;
   bit running = 0;

   // Reference model state
   logic [7:0] cmd_exp[$];
   int         ram_exp_a[$];
   logic [7:0] ram_exp_d[$];
   int         ptr_m = 0;
   bit         prev_cmd = 0;
   bit         prev_we = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic void want_cmd(input logic [7:0] b);
      cmd_exp.push_back(b);
   endfunction

   function automatic void want_ram(input logic [7:0] b);
      ram_exp_a.push_back(ptr_m);
      ram_exp_d.push_back(b);
      ptr_m = (ptr_m + 1) % 128;
   endfunction

   // Per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && running) begin
         if (cmd_stb_o) begin
            if (cmd_exp.size() == 0)
               check(0, "R8", "unexpected command strobe", cmd_byte_o, 0);
            else begin
               logic [7:0] e;
               e = cmd_exp.pop_front();
               check(cmd_byte_o == e, "R8", "command byte", cmd_byte_o, e);
            end
            if (prev_cmd) check(0, "R8", "strobe longer than one cycle", 1, 0);
         end
         if (ram_we_o) begin
            if (ram_exp_a.size() == 0)
               check(0, "R9", "unexpected RAM write", ram_data_o, 0);
            else begin
               int         ea;
               logic [7:0] ed;
               ea = ram_exp_a.pop_front();
               ed = ram_exp_d.pop_front();
               check(int'(ram_addr_o) == ea, "R9", "RAM address", ram_addr_o, ea);
               check(ram_data_o == ed, "R9", "RAM data", ram_data_o, ed);
            end
            if (prev_we) check(0, "R9", "write enable longer than one cycle", 1, 0);
         end
         if (cmd_stb_o && ram_we_o) check(0, "R12", "both outputs active", 1, 0);
         prev_cmd = cmd_stb_o;
         prev_we  = ram_we_o;
      end
   end

   task automatic hq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_drv = 1'b1; hq();
      scl_drv = 1'b1; hq();
      sda_drv = 1'b0; hq();
      scl_drv = 1'b0; hq();
   endtask

   task automatic i2c_stop();
      sda_drv = 1'b0; hq();
      scl_drv = 1'b1; hq();
      sda_drv = 1'b1; hq();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_drv = b[i]; hq();
         scl_drv = 1'b1; hq(); hq();
         scl_drv = 1'b0; hq();
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
      send_bits(b, 8);
      sda_drv = 1'b1; hq();
      scl_drv = 1'b1; hq();
      check(sda_pull_o == exp_ack, req, "acknowledge on ninth clock",
            sda_pull_o, exp_ack);
      hq();
      scl_drv = 1'b0; hq();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nchk++;
         nbad++;
         $display("FAIL watchdog run did not finish actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(!sda_pull_o, "R11", "pull after reset", sda_pull_o, 0);
      check(!cmd_stb_o, "R11", "strobe after reset", cmd_stb_o, 0);
      check(!ram_we_o, "R11", "write enable after reset", ram_we_o, 0);
      check(ram_addr_o == 0, "R11", "pointer after reset", ram_addr_o, 0);
      running = 1;
      hq();

      // R1 R5 R7 R9: address 0111110, mixed continuation words
      i2c_start();
      send_byte(8'h7C, 1, "R1");
      send_byte(8'h80, 1, "R4");
      want_cmd(8'h38);
      send_byte(8'h38, 1, "R5");
      send_byte(8'hC0, 1, "R4");
      want_ram(8'h41);
      send_byte(8'h41, 1, "R5");
      send_byte(8'h40, 1, "R6");
      want_ram(8'h42);
      send_byte(8'h42, 1, "R6");
      want_ram(8'h43);
      send_byte(8'h43, 1, "R6");
      i2c_stop();
      hq();

      // R3: another target's address, then a repeated START to ours
      sel = 2'b01;
      i2c_start();
      send_byte(8'h7C, 0, "R3");
      send_byte(8'h80, 0, "R3");
      send_byte(8'h55, 0, "R3");
      i2c_start();
      send_byte(8'h7A, 1, "R1");
      send_byte(8'h00, 1, "R6");
      want_cmd(8'h11);
      send_byte(8'h11, 1, "R6");
      want_cmd(8'h22);
      send_byte(8'h22, 1, "R6");
      i2c_stop();
      hq();

      // R2: read bit set
      sel = 2'b00;
      i2c_start();
      send_byte(8'h79, 0, "R2");
      send_byte(8'h40, 0, "R2");
      i2c_stop();
      hq();

      // R7: junk in control bits 5..0
      i2c_start();
      send_byte(8'h78, 1, "R1");
      send_byte(8'hBF, 1, "R7");
      want_cmd(8'h5A);
      send_byte(8'h5A, 1, "R7");
      send_byte(8'h7F, 1, "R7");
      want_ram(8'hA5);
      send_byte(8'hA5, 1, "R7");
      want_ram(8'h5B);
      send_byte(8'h5B, 1, "R7");
      i2c_stop();
      hq();

      // R10: repeated START mid-byte while in tail mode, then STOP mid-byte
      i2c_start();
      send_byte(8'h78, 1, "R10");
      send_byte(8'h40, 1, "R10");
      want_ram(8'h01);
      send_byte(8'h01, 1, "R10");
      send_bits(8'hFF, 3);
      i2c_start();
      send_byte(8'h78, 1, "R10");
      send_byte(8'h80, 1, "R10");
      want_cmd(8'h99);
      send_byte(8'h99, 1, "R10");
      send_byte(8'h40, 1, "R10");
      send_bits(8'h6D, 5);
      i2c_stop();
      hq();
      i2c_start();
      send_byte(8'h78, 1, "R10");
      send_byte(8'h40, 1, "R10");
      want_ram(8'h77);
      send_byte(8'h77, 1, "R10");
      i2c_stop();
      hq();

      // R9: long burst across the pointer wrap
      i2c_start();
      send_byte(8'h78, 1, "R9");
      send_byte(8'h40, 1, "R9");
      for (int i = 0; i < 130; i++) begin
         logic [7:0] d;
         d = 8'(i) ^ 8'h3C;
         want_ram(d);
         send_byte(d, 1, "R4");
      end
      i2c_stop();
      hq();

      check(cmd_exp.size() == 0, "R8", "command strobes missing",
            cmd_exp.size(), 0);
      check(ram_exp_a.size() == 0, "R9", "RAM writes missing",
            ram_exp_a.size(), 0);
      check(int'(ram_addr_o) == (ptr_m + 127) % 128, "R9", "final pointer",
            ram_addr_o, (ptr_m + 127) % 128);

      done = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

endmodule